// File: doc/BRIEF.md
# Serial TDM Stream Receiver

This block receives one serial stream of a frame-synchronous time-division-multiplexed bus and turns it into parallel bytes. It runs on an oversampling clock at four times the fastest bit rate (32.768 MHz for 8.192 Mb/s). It watches a frame-reference clock and a frame pulse, both sampled on that clock, to find the frame boundary. The active edge of the reference clock and the active level of the pulse are each chosen by a polarity input.

Once it has found a boundary, the receiver counts oversampling ticks through the 125 us frame. It samples the serial data once per bit, at a programmable quarter of the bit period. It places channel 0 a programmable number of whole channels and whole bits after the boundary, and shifts bits in most significant first. Each completed channel comes out as a byte with a one-cycle valid strobe, the channel index and a flag that marks channel 0. Configuration inputs are static: they are changed only while reset is asserted.

Top module: `tdm_rx`

## Requirements
- R1: `rate_sel` picks the bit rate. 0 gives 2.048 Mb/s (16 ticks per bit, 32 channels), 1 gives 4.096 Mb/s (8 ticks, 64 channels), and 2 or 3 gives 8.192 Mb/s (4 ticks, 128 channels). A frame is always 4096 ticks long, and `ch_o` never reaches the channel count of the selected rate.
- R2: With `fp_pol`=0 and `ck_pol`=0, a frame boundary is a falling edge of `ref_ck` seen while `fp_in` is low. Reference edges seen while the pulse is inactive are ignored. Tick 0 of the frame is the cycle after the cycle in which the edge is seen.
- R3: `ck_pol`=1 makes the rising edge of `ref_ck` the active edge, and `fp_pol`=1 makes high the active level of `fp_in`. The two bits act independently.
- R4: `samp_q`=q samples each bit on the last tick of quarter q of the bit period. The value 2 gives the three-quarter point. Data present only during quarter q must be received correctly.
- R5: The most significant bit of channel 0 starts (8*`ch_dly` + `bit_dly`) bit periods after the boundary. Channels that are pushed past the end of the frame wrap to its start.
- R6: Bits are assembled most significant first. `byte_vld` pulses for one cycle, in the cycle after the eighth bit of a channel is sampled. In that cycle `byte_o` and `ch_o` hold that channel's data and index.
- R7: `frame_o` is 1 on a valid byte exactly when `ch_o` is 0.
- R8: No byte is produced before the first boundary. No byte is produced for a channel whose most significant bit was not sampled after the first boundary.
- R9: While and after reset, `byte_vld` is 0 until a complete byte has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 4x the highest bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Bit-rate select |
| fp_pol | input | 1 | Frame-pulse active level (0 = low) |
| ck_pol | input | 1 | Reference-clock active edge (0 = falling) |
| samp_q | input | 2 | Sampling quarter inside a bit |
| ch_dly | input | 7 | Whole-channel delay of the stream |
| bit_dly | input | 3 | Whole-bit delay of the stream |
| ref_ck | input | 1 | Frame-reference clock, sampled on clk |
| fp_in | input | 1 | Frame pulse, sampled on clk |
| sdi | input | 1 | Serial data in |
| byte_o | output | 8 | Received byte |
| byte_vld | output | 1 | One-cycle strobe for byte_o |
| ch_o | output | 7 | Channel index of byte_o |
| frame_o | output | 1 | Marks the byte of channel 0 |

## Verification
A tick counter that has slipped off the boundary, or a wrong sampling quarter, corrupts the first byte completed after the fault, so the error shows at the ports within one channel time (at most 128 ticks). A wrong delay decode shows up as a wrong `ch_o` tag on the very first byte. A priming flag or lock flag that is set too early shows up as an unexpected strobe before the first boundary or during the first partial channel. The bench drives each bit correctly only inside the selected quarter and inverted elsewhere, so any sampling offset gives wrong data bits.

// File: rtl/tdm_rx.sv
module tdm_rx #(
  parameter int CHW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     rate_sel,
  input  logic           fp_pol,
  input  logic           ck_pol,
  input  logic [1:0]     samp_q,
  input  logic [CHW-1:0] ch_dly,
  input  logic [2:0]     bit_dly,
  input  logic           ref_ck,
  input  logic           fp_in,
  input  logic           sdi,
  output logic [7:0]     byte_o,
  output logic           byte_vld,
  output logic [CHW-1:0] ch_o,
  output logic           frame_o
);
  localparam int BITW  = CHW + 3;
  localparam int TICKW = CHW + 5;

  logic             ck_d;
  logic [TICKW-1:0] tick;
  logic             locked, primed;
  logic [6:0]       sr;

  wire [1:0] r = (rate_sel == 2'd3) ? 2'd2 : rate_sel;

  wire boundary = (ck_d != ref_ck) && (ref_ck == ck_pol) && (fp_in == fp_pol);

  wire [TICKW-1:0] bitpos_w = tick >> (3'd4 - {1'b0, r});
  wire [BITW-1:0]  bitpos   = bitpos_w[BITW-1:0];
  wire [BITW:0]    nbits    = (BITW+1)'(1) << (BITW - 2 + int'(r));
  wire [BITW:0]    bmask    = nbits - (BITW+1)'(1);
  wire [BITW-1:0]  idx      = (bitpos - {ch_dly, bit_dly}) & bmask[BITW-1:0];
  wire [CHW-1:0]   chan     = idx[BITW-1:3];
  wire [2:0]       bitnum   = idx[2:0];

  wire [4:0] in_bit  = {1'b0, tick[3:0] & (4'hF >> r)};
  wire [4:0] samp_at = ((5'(samp_q) + 5'd1) << (2'd2 - r)) - 5'd1;
  wire       samp    = locked && (in_bit == samp_at);

  always_ff @(posedge clk) ck_d <= ref_ck;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick     <= '0;
      locked   <= 1'b0;
      primed   <= 1'b0;
      sr       <= '0;
      byte_o   <= '0;
      byte_vld <= 1'b0;
      ch_o     <= '0;
      frame_o  <= 1'b0;
    end else begin
      if (boundary) begin
        tick   <= '0;
        locked <= 1'b1;
      end else if (locked) begin
        tick <= tick + 1'b1;
      end
      if (samp) begin
        sr <= {sr[5:0], sdi};
        if (bitnum == 3'd0) primed <= 1'b1;
      end
      byte_vld <= samp && primed && (bitnum == 3'd7);
      if (samp && primed && (bitnum == 3'd7)) begin
        byte_o  <= {sr, sdi};
        ch_o    <= chan;
        frame_o <= (chan == '0);
      end
    end
  end

  assert_byte_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
  assert_frame_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (frame_o == (ch_o == '0)));
  assert_chan_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> ({1'b0, ch_o} < ((CHW+1)'(1) << (CHW - 2 + int'(r)))));
  assert_no_early_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (locked && primed));
  assert_lock_on_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> tick == '0);
endmodule

// File: tb/tdm_rx_bench.sv
module tdm_rx_bench;
  localparam int CLK_P = 10;
  localparam int B0 = 102;
  localparam int FRAME = 4096;

  logic clk = 0, rst_n = 0;
  logic [1:0] rate_sel = 2, samp_q = 2;
  logic fp_pol = 0, ck_pol = 0;
  logic [6:0] ch_dly = 0;
  logic [2:0] bit_dly = 0;
  logic ref_ck = 1, fp_in = 1, sdi = 0;
  logic [7:0] byte_o;
  logic byte_vld, frame_o;
  logic [6:0] ch_o;

  int checks = 0, fails = 0;
  logic [15:0] expq[$];

  always #(CLK_P/2) clk = ~clk;

  tdm_rx u_tdm_rx (.clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .fp_pol(fp_pol),
    .ck_pol(ck_pol), .samp_q(samp_q), .ch_dly(ch_dly), .bit_dly(bit_dly),
    .ref_ck(ref_ck), .fp_in(fp_in), .sdi(sdi), .byte_o(byte_o),
    .byte_vld(byte_vld), .ch_o(ch_o), .frame_o(frame_o));

  // Monitor: every strobe must match the head of the queue (R6, R7); none may appear unexpected (R8).
  always @(negedge clk) begin
    if (rst_n && byte_vld) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R8 unexpected byte ch=%0d data=%02h expected none", ch_o, byte_o);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        if ({ch_o, byte_o, frame_o} !== e)
          begin
            fails++;
            $display("FAIL R6/R7 ch=%0d data=%02h fs=%0b expected ch=%0d data=%02h fs=%0b",
                     ch_o, byte_o, frame_o, e[15:9], e[8:1], e[0]);
          end
      end
    end
  end

  task automatic run(input int id, input logic [1:0] rt, input logic [1:0] q,
                     input logic fpp, input logic ckp, input int cd, input int bd);
    int tpb, bits, dly, nmax;
    bit primed;
    rst_n = 0;
    rate_sel = rt; samp_q = q; fp_pol = fpp; ck_pol = ckp;
    ch_dly = 7'(cd); bit_dly = 3'(bd);
    expq.delete();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    checks++;
    if (byte_vld !== 1'b0) begin
      fails++;
      $display("FAIL R9 run %0d byte_vld=%0b expected 0", id, byte_vld);
    end
    tpb  = (rt == 3) ? 4 : (16 >> rt);
    bits = (rt == 3) ? 1024 : (256 << rt);
    dly  = cd * 8 + bd;
    primed = 0;
    nmax = B0 + 1 + 3 * FRAME + 8;
    @(posedge clk);
    for (int n = 0; n < nmax; n++) begin
      int rel, t;
      #1;
      ref_ck = ckp ? ((n % 4) >= 2) : ((n % 4) < 2);
      rel = (n - B0 + FRAME) % FRAME;
      fp_in = ((rel == FRAME - 1) || (rel <= 2)) ? fpp : ~fpp;
      t = n - B0 - 1;
      if (t < 0) sdi = 1'($urandom);
      else begin
        int tick, g, a, idx, ch, b, fr, pat, qtr, bv;
        tick = t % FRAME;
        g = t / tpb;
        a = g - dly;
        idx = ((a % bits) + bits) % bits;
        ch = idx / 8; b = idx % 8;
        fr = (a + 4 * bits) / bits;
        pat = (ch * 29 + fr * 53 + id * 7 + 1) & 255;
        bv = (pat >> (7 - b)) & 1;
        qtr = (tick % tpb) / (tpb / 4);
        sdi = (qtr == q) ? 1'(bv) : ~1'(bv);
        if ((tick % tpb) == (q + 1) * (tpb / 4) - 1) begin
          if (b == 0) primed = 1;
          if (b == 7 && primed) expq.push_back({7'(ch), 8'(pat), ch == 0});
        end
      end
      @(posedge clk);
    end
    repeat (4) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R6 run %0d missing bytes=%0d expected 0", id, expq.size());
    end
  endtask

  initial begin
    // R1 R2 R4: 8.192 Mb/s, negative format, three-quarter point, no delay
    run(1, 2'd2, 2'd2, 1'b0, 1'b0, 0, 0);
    // R1 R4 R5: 2.048 Mb/s, first quarter, channel and bit delay
    run(2, 2'd0, 2'd0, 1'b0, 1'b0, 3, 5);
    // R1 R3 R5: 4.096 Mb/s, both polarities positive, delay wraps past frame end
    run(3, 2'd1, 2'd3, 1'b1, 1'b1, 63, 7);
    // R3 R4 R5 R8: 8.192 Mb/s, pulse high active, falling edge, largest channel delay
    run(4, 2'd2, 2'd1, 1'b1, 1'b0, 127, 1);
    // R1: rate code 3 behaves as 8.192 Mb/s
    run(5, 2'd3, 2'd2, 1'b0, 1'b1, 10, 2);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule